// File: doc/BRIEF.md
# Memory Decoder Register Bank

This block holds the software-visible configuration of four host-managed memory address decoders. Each decoder has a region base and a region size, each split into a low and a high 32-bit word. It also has a control word and a two-word target list. A read-only capability word and a global control word sit in front of the decoder slots. All registers are 32 bits wide and little endian. They are reached over a plain register bus that carries a byte address, a write strobe, write data and combinational read data.

Every write is merged through a writable mask fixed for that register. Bits outside the mask keep their stored value. A write to a decoder control word also runs a commit handshake. The written request bit sets or clears a read-only committed status bit, and the stored error bit is always cleared. An 8-byte access is flagged by `reg_wide`; the bank ignores it on write and returns zero for it on read. A helper output turns the granularity field of a selected decoder into a size in bytes.

Register layout (byte addresses): capability at 0x00, global control at 0x04. Decoder n occupies 0x10 + n*0x20. Within a slot: +0x00 base low, +0x04 base high, +0x08 size low, +0x0C size high, +0x10 control, +0x14 target low, +0x18 target high. Control word fields: [3:0] granularity code, [9] commit request, [10] committed, [11] error.

Top module: `memdec_regbank`

## Requirements
- R1: A write replaces only the bits set in the register's writable mask; every other bit keeps its previous value.
- R2: The capability word at 0x00 reads 0x0000_0312 and writes do not change it. The fields are: decoder-count code 2 in [3:0], target count 1 in [7:4], 256-byte interleave support in [8], 4 KiB interleave support in [9], and no poison-on-error support in [10].
- R3: In base-low and size-low only bits [31:28] are writable, so regions are 256 MiB aligned. Base-high, size-high and both target-list words are fully writable.
- R4: A decoder control word has the writable mask 0x0000_13FF.
- R5: A control write with bit [9] set stores committed bit [10] as 1 and error bit [11] as 0.
- R6: A control write with bit [9] clear stores both bit [10] and bit [11] as 0.
- R7: Bit [10] of a control word changes only through a write to that control word.
- R8: With `reg_wide` high, a write has no effect and a read returns zero. Unaligned or unmapped addresses read as zero and writes to them have no effect.
- R9: `gran_bytes` equals 1 shifted left by (granularity code + 8), taken from control bits [3:0] of the decoder chosen by `gran_sel`.
- R10: A synchronous active-high reset clears every register except the capability word.
- R11: The global control word at 0x04 has writable bits [1:0]; its decoder-enable bit [1] resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte address of the access |
| reg_wr_en | input | 1 | Write strobe |
| reg_wide | input | 1 | Marks an 8-byte access (unsupported) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| gran_sel | input | 2 | Decoder whose granularity is reported |
| gran_bytes | output | 32 | Interleave granularity in bytes |

## Verification
The bench builds the bank with its defaults: four decoders and an 8-bit address. At that size the whole map, including the unmapped tail and unaligned addresses, fits in one sweep of 0x00 to 0x8F. Random writes spread over every slot therefore hit each mask type, both commit directions and wide accesses. Every register can be compared against the bench model after each burst. All sixteen granularity codes are reachable through the four-bit field, so the largest shift, 8 MiB, is checked directly.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    F_BASE_LO = 3'd0,
    F_BASE_HI = 3'd1,
    F_SIZE_LO = 3'd2,
    F_SIZE_HI = 3'd3,
    F_CTRL    = 3'd4,
    F_TGT_LO  = 3'd5,
    F_TGT_HI  = 3'd6,
    F_NONE    = 3'd7
  } fld_e;

  localparam int CTL_COMMIT    = 9;
  localparam int CTL_COMMITTED = 10;
  localparam int CTL_ERR       = 11;

  localparam logic [REG_W-1:0] CTRL_WMASK = 32'h0000_13FF;
  localparam logic [REG_W-1:0] LO_WMASK   = 32'hF000_0000;
  localparam logic [REG_W-1:0] GLB_WMASK  = 32'h0000_0003;

  function automatic logic [REG_W-1:0] merge_wr(logic [REG_W-1:0] old_v,
                                                 logic [REG_W-1:0] new_v,
                                                 logic [REG_W-1:0] mask);
    return (new_v & mask) | (old_v & ~mask);
  endfunction

  function automatic logic [3:0] count_code(int n);
    return (n == 1) ? 4'd0 : 4'(n / 2);
  endfunction

  function automatic logic [REG_W-1:0] cap_word(int n);
    return {21'd0, 1'b0, 1'b1, 1'b1, 4'd1, count_code(n)};
  endfunction

  function automatic logic [REG_W-1:0] gran_of(logic [3:0] code);
    return 32'd1 << (32'(code) + 32'd8);
  endfunction
endpackage

// File: rtl/memdec_addr_dec.sv
module memdec_addr_dec
  import memdec_pkg::*;
#(
  parameter int NUM_DEC = 4,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               sel_cap,
  output logic               sel_glb,
  output logic [NUM_DEC-1:0] dec_sel,
  output fld_e               fld
);
  localparam int WA       = ADDR_W - 2;
  localparam int BASE_W   = 4;
  localparam int STRIDE_L = 3;
  localparam int IDX_W    = WA - STRIDE_L;

  logic          aligned;
  logic [WA-1:0] off_w;
  logic          in_range;

  assign aligned  = (addr[1:0] == 2'b00);
  assign sel_cap  = (addr == '0);
  assign sel_glb  = (addr == ADDR_W'(4));
  assign off_w    = addr[ADDR_W-1:2] - WA'(BASE_W);
  assign in_range = aligned && (addr[ADDR_W-1:2] >= WA'(BASE_W)) &&
                    (int'(off_w[WA-1:STRIDE_L]) < NUM_DEC);
  assign fld      = in_range ? fld_e'(off_w[2:0]) : F_NONE;

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_sel
    assign dec_sel[g] = in_range && (off_w[WA-1:STRIDE_L] == IDX_W'(g));
  end
endmodule

// File: rtl/memdec_slot.sv
module memdec_slot
  import memdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  fld_e             fld,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rd_word,
  output logic [3:0]       ig_code
);
  logic [REG_W-1:0] base_lo_q, base_hi_q, size_lo_q, size_hi_q;
  logic [REG_W-1:0] ctrl_q, tgt_lo_q, tgt_hi_q;
  logic [REG_W-1:0] ctrl_nxt;
  logic             wr_ctrl, commit_req, uncommit_req;

  assign wr_ctrl      = wr_en && (fld == F_CTRL);
  assign commit_req   = wr_ctrl && wdata[CTL_COMMIT];
  assign uncommit_req = wr_ctrl && !wdata[CTL_COMMIT];

  always_comb begin
    ctrl_nxt                = merge_wr(ctrl_q, wdata, CTRL_WMASK);
    ctrl_nxt[CTL_COMMITTED] = commit_req;
    ctrl_nxt[CTL_ERR]       = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo_q <= '0; base_hi_q <= '0; size_lo_q <= '0; size_hi_q <= '0;
      ctrl_q    <= '0; tgt_lo_q  <= '0; tgt_hi_q  <= '0;
    end else if (wr_en) begin
      case (fld)
        F_BASE_LO: base_lo_q <= merge_wr(base_lo_q, wdata, LO_WMASK);
        F_BASE_HI: base_hi_q <= wdata;
        F_SIZE_LO: size_lo_q <= merge_wr(size_lo_q, wdata, LO_WMASK);
        F_SIZE_HI: size_hi_q <= wdata;
        F_CTRL:    ctrl_q    <= ctrl_nxt;
        F_TGT_LO:  tgt_lo_q  <= wdata;
        F_TGT_HI:  tgt_hi_q  <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (fld)
      F_BASE_LO: rd_word = base_lo_q;
      F_BASE_HI: rd_word = base_hi_q;
      F_SIZE_LO: rd_word = size_lo_q;
      F_SIZE_HI: rd_word = size_hi_q;
      F_CTRL:    rd_word = ctrl_q;
      F_TGT_LO:  rd_word = tgt_lo_q;
      F_TGT_HI:  rd_word = tgt_hi_q;
      default:   rd_word = '0;
    endcase
  end

  assign ig_code = ctrl_q[3:0];

  AST_COMMIT_SETS: assert property (@(posedge clk) disable iff (rst)
    commit_req |=> (ctrl_q[CTL_COMMITTED] && !ctrl_q[CTL_ERR])); // R5
  AST_UNCOMMIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    uncommit_req |=> (!ctrl_q[CTL_COMMITTED] && !ctrl_q[CTL_ERR])); // R6
  AST_COMMITTED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(ctrl_q[CTL_COMMITTED])); // R7
  AST_BASE_LO_TOP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fld == F_BASE_LO) |=> (base_lo_q[31:28] == $past(wdata[31:28]))); // R3
endmodule

// File: rtl/memdec_regbank.sv
module memdec_regbank
  import memdec_pkg::*;
#(
  parameter int NUM_DEC = 4,
  parameter int ADDR_W  = 8,
  localparam int SEL_W  = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic              reg_wide,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [SEL_W-1:0]  gran_sel,
  output logic [31:0]       gran_bytes
);
  localparam logic [REG_W-1:0] CAP_VAL = cap_word(NUM_DEC);

  logic               sel_cap, sel_glb, wr_ok;
  logic [NUM_DEC-1:0] dec_sel;
  fld_e               fld;
  logic [1:0]         glb_q;
  logic [REG_W-1:0]   slot_rd [NUM_DEC];
  logic [3:0]         slot_ig [NUM_DEC];

  memdec_addr_dec #(.NUM_DEC(NUM_DEC), .ADDR_W(ADDR_W)) u_dec (
    .addr(reg_addr), .sel_cap(sel_cap), .sel_glb(sel_glb),
    .dec_sel(dec_sel), .fld(fld)
  );

  assign wr_ok = reg_wr_en && !reg_wide;

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_slot
    memdec_slot u_slot (
      .clk(clk), .rst(rst), .wr_en(wr_ok && dec_sel[g]), .fld(fld),
      .wdata(reg_wdata), .rd_word(slot_rd[g]), .ig_code(slot_ig[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                  glb_q <= '0;
    else if (wr_ok && sel_glb) glb_q <= reg_wdata[1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_wide) begin
      if (sel_cap) reg_rdata = CAP_VAL;
      if (sel_glb) reg_rdata = merge_wr('0, {30'd0, glb_q}, GLB_WMASK);
      for (int i = 0; i < NUM_DEC; i++)
        if (dec_sel[i]) reg_rdata = slot_rd[i];
    end
  end

  assign gran_bytes = gran_of(slot_ig[gran_sel]);

  AST_WIDE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_wide |-> (reg_rdata == '0)); // R8
  AST_GLB_MASKED: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && sel_glb) |=> (glb_q == $past(reg_wdata[1:0]))); // R11
  AST_GRAN_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    $countones(gran_bytes) == 1); // R9
  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_cap, sel_glb, dec_sel})); // R8
endmodule

// File: tb/memdec_regbank_tb.sv
`timescale 1ns/1ps
module memdec_regbank_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  reg_addr = 0;
  logic        reg_wr_en = 0, reg_wide = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [1:0]  gran_sel = 0;
  logic [31:0] gran_bytes;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m [0:255];

  always #2.5 clk = ~clk;

  memdec_regbank dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wide(reg_wide), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gran_sel(gran_sel), .gran_bytes(gran_bytes)
  );

  function automatic logic [31:0] wmask(int a);
    if (a == 4) return 32'h3;
    if (a >= 16 && a < 144 && (a % 4) == 0) begin
      case (((a - 16) % 32) / 4)
        0, 2:          return 32'hF000_0000;
        1, 3, 5, 6:    return 32'hFFFF_FFFF;
        4:             return 32'h0000_13FF;
        default:       return 32'h0;
      endcase
    end
    return 32'h0;
  endfunction

  function automatic bit is_ctrl(int a);
    return a >= 16 && a < 144 && (a % 4) == 0 && ((a - 16) % 32) == 16;
  endfunction

  function automatic string tag_of(int a);
    if (a == 0) return "R2";
    if (a == 4) return "R11";
    if (is_ctrl(a)) return "R4";
    if (wmask(a) == 32'hF000_0000 || wmask(a) == 32'hFFFF_FFFF) return "R3";
    return "R8";
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m[i] = 0;
    m[0] = 32'h0000_0312;
  endtask

  task automatic wr(int a, logic [31:0] d, bit wide);
    logic [31:0] v;
    @(negedge clk);
    reg_addr = 8'(a); reg_wdata = d; reg_wide = wide; reg_wr_en = 1;
    @(negedge clk);
    reg_wr_en = 0; reg_wide = 0;
    if (!wide) begin
      v = (d & wmask(a)) | (m[a] & ~wmask(a));
      if (is_ctrl(a)) begin
        v[10] = d[9];
        v[11] = 1'b0;
      end
      m[a] = v;
    end
  endtask

  task automatic rd_chk(int a, string tag);
    @(negedge clk);
    reg_addr = 8'(a); reg_wide = 0; reg_wr_en = 0;
    #1;
    check(tag, reg_rdata, m[a]);
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 144; a++) rd_chk(a, tag);
  endtask

  task automatic gran_chk(int d);
    @(negedge clk);
    gran_sel = 2'(d);
    #1;
    check("R9", gran_bytes, 32'h100 << m[16 + 32*d + 16][3:0]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [31:0] rv;
    seed = $urandom(32'h5eed_1234);
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    sweep("R10");                                 // R10 reset state, R2 capability
    gran_chk(0);                                  // R9 code 0 -> 256

    wr(16, 32'hFFFF_FFFF, 0); rd_chk(16, "R3");   // R3 base low top nibble only
    wr(20, 32'hA5A5_5A5A, 0); rd_chk(20, "R3");   // R3 base high full
    wr(24, 32'h1234_5678, 0); rd_chk(24, "R1");   // R1 size low merge
    wr(32, 32'hFFFF_FFFF, 0); rd_chk(32, "R5");   // R4 R5 commit -> 0x17FF
    check("R5", m[32], 32'h0000_17FF);
    gran_chk(0);                                  // R9 code 15 -> 8 MiB
    check("R9", gran_bytes, 32'h0080_0000);
    wr(32, 32'h0000_0003, 0); rd_chk(32, "R6");   // R6 uncommit
    wr(32, 32'h0000_0200, 0); rd_chk(32, "R5");
    wr(36, 32'h0, 0); rd_chk(32, "R7");           // R7 other write keeps committed
    wr(48, 32'hDEAD_BEEF, 1); rd_chk(48, "R8");   // R8 wide write ignored
    @(negedge clk); reg_addr = 8'd32; reg_wide = 1; #1;
    check("R8", reg_rdata, 32'h0);                // R8 wide read zero
    wr(4, 32'hFFFF_FFFF, 0); rd_chk(4, "R11");    // R11 global mask
    wr(0, 32'hFFFF_FFFF, 0); rd_chk(0, "R2");     // R2 capability read-only
    wr(17, 32'hFFFF_FFFF, 0); rd_chk(17, "R8");   // R8 unaligned
    wr(140, 32'hFFFF_FFFF, 0); rd_chk(140, "R8"); // R8 unmapped slot word

    for (int i = 0; i < 400; i++) begin
      int a;
      bit w;
      a = int'($urandom % 144);
      if ($urandom % 4 != 0) a = a & ~3;
      w = ($urandom % 8) == 0;
      rv = $urandom;
      if ($urandom % 3 == 0) rv[9] = ~rv[9];
      wr(a, rv, w);
      rd_chk(a, tag_of(a));                       // R1 R4 R5 R6 random
      if (i % 100 == 99) begin
        sweep("R7");                              // R7 committed bits intact
        for (int d = 0; d < 4; d++) gran_chk(d);
      end
    end

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    model_reset();
    sweep("R10");                                 // R10 reset after traffic

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule